// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Compare Test Mode

This block is the device-side control logic of an asynchronous 1M x 4 dynamic memory. It is written as synchronous logic: the active-low row strobe, column strobe, write enable and output enable are sampled by a fast clock, and each strobe edge is found by comparing the current pin level with the level seen one clock earlier. When the row strobe falls, the block decides what kind of cycle is starting from the levels of the column strobe and write enable at that moment. The cycle is one of four kinds: a row activation with an external address, a refresh driven by an internal row counter, the same counter refresh with test-mode entry, or a row activation that ends without a column strobe, which is a refresh from an external address.

Within an open row, each falling column strobe latches a column address. The access then becomes a read, an early write or a read-modify-write. Further column pulses stay in the same row, which gives page-mode access. The storage is a small behavioural register file that only uses the low address bits. While test mode is active, reads do not return the stored word. They return a pass/fail level built from comparing two stored bits.

Each row-strobe classification is reported on a one-cycle event output, carrying the cycle kind and the row being opened or refreshed. The row drivers of the array take this as their command.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, test mode is off, the data output is not driven (`dq_oe`=0, `dout`=0), no event is flagged, and the first counter refresh uses row 0.
- R2: A row-strobe fall with the column strobe high raises `evt_valid` for exactly one cycle, starting the cycle after the edge is sampled, with `evt_kind`=0 and `evt_row` equal to the address pins.
- R3: A row-strobe fall with the column strobe low and write enable high is a counter refresh. It reports `evt_kind`=1 and `evt_row` equal to the counter, advances the counter by one, and turns test mode off.
- R4: A row-strobe fall with both the column strobe and write enable low is a test-entry refresh. It reports `evt_kind`=2 and `evt_row` equal to the counter, advances the counter, and turns test mode on. It leaves test mode on if it was already on.
- R5: A row activation that ends with no column-strobe fall turns test mode off. A row activation that carried at least one column access leaves test mode unchanged.
- R6: A column-strobe fall with write enable high, inside an open row, is a read. From the next cycle, `dout` holds the word at index {row[2:0], col[2:0]}. `dq_oe` is 1 only while the column strobe and output enable are both low, and it drops as soon as the column strobe rises.
- R7: A column-strobe fall with write enable already low is an early write. It stores `din` at {row[2:0], col[2:0]}, and `dq_oe` stays 0 for that whole pulse even with output enable low.
- R8: A write-enable fall during a read pulse stores `din` at the latched location. Until the column strobe rises, `dout` keeps showing the word that was read.
- R9: Column pulses repeated while the row strobe stays low all access the row latched at activation, each pulse at its own column.
- R10: In test mode, a read drives all four `dout` bits high if the stored bits of pair p = col mod 2 are equal (bits 1:0 for p=0, bits 3:2 for p=1), and all low otherwise.
- R11: If the column strobe stays low through a row-strobe rise and the next row-strobe fall, the cycle is a counter refresh. Read data already on `dout` stays driven and unchanged during it.
- R12: The refresh counter is 10 bits wide and wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, zero when not driven |
| dq_oe | output | 1 | Data output driven (0 models high impedance) |
| test_mode | output | 1 | Compare test mode active |
| evt_valid | output | 1 | One-cycle row-strobe event flag |
| evt_kind | output | 2 | Event kind: 0 row activation, 1 counter refresh, 2 test-entry refresh |
| evt_row | output | 10 | Row opened or refreshed by the event |

## Verification
The assertions assume that each strobe holds its level for at least one clock. They also assume that the column strobe never falls in the same sample as the row strobe, since that pair of edges would make the refresh/access decision ambiguous. The address and write data are assumed stable across the sample in which a strobe edge is seen. The stimulus meets these assumptions by changing every input only on the falling clock edge and by separating each strobe transition from the next by at least one full clock. The row and column sweeps cover every location of the small array. Aliased high address bits are used on the readback pass.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [1:0] {
    EV_ROW  = 2'd0,
    EV_CBR  = 2'd1,
    EV_WCBR = 2'd2,
    EV_NONE = 2'd3
  } evt_kind_t;

  // next value of a w-bit wrapping counter
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned w);
    return (v + 1) % (32'd1 << w);
  endfunction

  // equality of the two bits forming pair p of a word
  function automatic logic pair_equal(input logic [63:0] word, input int unsigned p);
    return word[2*p] == word[2*p+1];
  endfunction

endpackage

// File: rtl/dcd_strobe.sv
module dcd_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic cas_rise,
  output logic we_fall
);

  logic ras_q, cas_q, we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign we_fall  = we_q & ~we_n;

endmodule

// File: rtl/dcd_cycle.sv
module dcd_cycle import dcd_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int ROW_LO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              row_open,
  output logic [ROW_LO-1:0] row_lo,
  output logic              test_mode,
  output logic              evt_valid,
  output evt_kind_t         evt_kind,
  output logic [ADDR_W-1:0] evt_row
);

  logic [ADDR_W-1:0] ref_ctr;
  logic              saw_cas;

  // named events for the checks below
  logic ctr_refresh_hit;
  logic test_entry_hit;
  logic row_hit;
  logic rasonly_hit;

  assign ctr_refresh_hit = ras_fall & ~cas_n;
  assign test_entry_hit  = ctr_refresh_hit & ~we_n;
  assign row_hit         = ras_fall & cas_n;
  assign rasonly_hit     = ras_rise & row_open & ~saw_cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ctr   <= '0;
      saw_cas   <= 1'b0;
      row_open  <= 1'b0;
      row_lo    <= '0;
      test_mode <= 1'b0;
      evt_valid <= 1'b0;
      evt_kind  <= EV_NONE;
      evt_row   <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (ctr_refresh_hit) begin
        evt_valid <= 1'b1;
        evt_kind  <= test_entry_hit ? EV_WCBR : EV_CBR;
        evt_row   <= ref_ctr;
        ref_ctr   <= ADDR_W'(wrap_inc(32'(ref_ctr), ADDR_W));
        test_mode <= test_entry_hit;
        row_open  <= 1'b0;
      end else if (row_hit) begin
        evt_valid <= 1'b1;
        evt_kind  <= EV_ROW;
        evt_row   <= addr;
        row_lo    <= addr[ROW_LO-1:0];
        row_open  <= 1'b1;
        saw_cas   <= 1'b0;
      end else if (ras_rise) begin
        row_open <= 1'b0;
        if (rasonly_hit) test_mode <= 1'b0;
      end else if (cas_fall && row_open) begin
        saw_cas <= 1'b1;
      end
    end
  end

  // R3: counter refresh advances the counter by one
  p_cbr_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_refresh_hit |=> (ref_ctr == $past(ref_ctr) + ADDR_W'(1)));

  // R3: plain counter refresh leaves test mode
  p_cbr_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);

  // R4: test-entry refresh turns test mode on
  p_wcbr_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_entry_hit |=> test_mode);

  // R5: row cycle without column access leaves test mode
  p_rasonly_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rasonly_hit |=> !test_mode);

  // R2: event flag lasts a single cycle
  p_evt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

endmodule

// File: rtl/dcd_array.sv
module dcd_array import dcd_pkg::*; #(
  parameter int DQ_W   = 4,
  parameter int ROW_LO = 3,
  parameter int COL_LO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_LO-1:0] row,
  input  logic [COL_LO-1:0] col,
  input  logic              wr_en,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic              test_sel,
  output logic [DQ_W-1:0]   rd_data
);

  localparam int IDX_W = ROW_LO + COL_LO;
  localparam int DEPTH = 1 << IDX_W;
  localparam int PAIRS = DQ_W / 2;

  logic [DQ_W-1:0]  mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic [DQ_W-1:0]  word;
  logic             pair_eq;

  assign idx     = {row, col};
  assign word    = mem[idx];
  assign pair_eq = pair_equal(64'(word), int'(col) % PAIRS);
  assign rd_data = test_sel ? {DQ_W{pair_eq}} : word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wr_data;
    end
  end

  // R7: a write lands at the addressed location
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(idx)] == $past(wr_data)));

endmodule

// File: rtl/dcd_column.sv
module dcd_column #(
  parameter int DQ_W   = 4,
  parameter int COL_LO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_fall,
  input  logic              cas_rise,
  input  logic              we_fall,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              row_open,
  input  logic [COL_LO-1:0] col_in,
  input  logic [DQ_W-1:0]   din,
  input  logic [DQ_W-1:0]   arr_rd,
  output logic [COL_LO-1:0] arr_col,
  output logic              arr_wr_en,
  output logic [DQ_W-1:0]   arr_wr_data,
  output logic [DQ_W-1:0]   dout,
  output logic              dq_oe
);

  logic [COL_LO-1:0] col_q;
  logic              rd_active;
  logic [DQ_W-1:0]   rd_q;

  logic read_hit;
  logic early_wr_hit;
  logic late_wr_hit;

  assign read_hit     = cas_fall & row_open & we_n;
  assign early_wr_hit = cas_fall & row_open & ~we_n;
  assign late_wr_hit  = we_fall & rd_active & ~cas_n & row_open;

  assign arr_col     = cas_fall ? col_in : col_q;
  assign arr_wr_en   = early_wr_hit | late_wr_hit;
  assign arr_wr_data = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      rd_active <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (cas_fall && row_open) col_q <= col_in;
      if (read_hit) begin
        rd_active <= 1'b1;
        rd_q      <= arr_rd;
      end else if (early_wr_hit || cas_rise) begin
        rd_active <= 1'b0;
      end
    end
  end

  assign dq_oe = rd_active & ~cas_n & ~oe_n;
  assign dout  = dq_oe ? rd_q : '0;

  // R7: early write keeps the output released
  p_early_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    early_wr_hit |=> !dq_oe);

  // R8: late write does not disturb data being shown
  p_rmw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    late_wr_hit |=> $stable(rd_q));

  // R6: a read with output enabled drives the pins next cycle
  p_read_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_hit && !oe_n) |=> (dq_oe || cas_n || oe_n));

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder import dcd_pkg::*; #(
  parameter int ADDR_W       = 10,
  parameter int DQ_W         = 4,
  parameter int ARR_ROW_BITS = 3,
  parameter int ARR_COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic [DQ_W-1:0]   dout,
  output logic              dq_oe,
  output logic              test_mode,
  output logic              evt_valid,
  output logic [1:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_row
);

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic row_open;
  logic [ARR_ROW_BITS-1:0] row_lo;
  logic [ARR_COL_BITS-1:0] arr_col;
  logic arr_wr_en;
  logic [DQ_W-1:0] arr_wr_data, arr_rd;
  evt_kind_t kind_w;

  dcd_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .cas_rise(cas_rise), .we_fall(we_fall)
  );

  dcd_cycle #(.ADDR_W(ADDR_W), .ROW_LO(ARR_ROW_BITS)) u_cycle (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .row_open(row_open), .row_lo(row_lo), .test_mode(test_mode),
    .evt_valid(evt_valid), .evt_kind(kind_w), .evt_row(evt_row)
  );

  dcd_column #(.DQ_W(DQ_W), .COL_LO(ARR_COL_BITS)) u_column (
    .clk(clk), .rst_n(rst_n), .cas_fall(cas_fall), .cas_rise(cas_rise),
    .we_fall(we_fall), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .row_open(row_open), .col_in(addr[ARR_COL_BITS-1:0]), .din(din),
    .arr_rd(arr_rd), .arr_col(arr_col), .arr_wr_en(arr_wr_en),
    .arr_wr_data(arr_wr_data), .dout(dout), .dq_oe(dq_oe)
  );

  dcd_array #(.DQ_W(DQ_W), .ROW_LO(ARR_ROW_BITS), .COL_LO(ARR_COL_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .row(row_lo), .col(arr_col),
    .wr_en(arr_wr_en), .wr_data(arr_wr_data), .test_sel(test_mode),
    .rd_data(arr_rd)
  );

  assign evt_kind = kind_w;

endmodule

// File: tb/sim_dram_cycle_decoder.sv
module sim_dram_cycle_decoder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ras_n, cas_n, we_n, oe_n;
  logic [9:0] addr;
  logic [3:0] din, dout;
  logic dq_oe, test_mode, evt_valid;
  logic [1:0] evt_kind;
  logic [9:0] evt_row;

  dram_cycle_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
    .test_mode(test_mode), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_row(evt_row)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [9:0] exp_ctr = '0;
  logic [3:0] model [64];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] pat(input int r, input int c);
    return 4'((r * 5 + c * 3 + 1) & 15);
  endfunction

  function automatic logic [3:0] cmp_exp(input logic [3:0] w, input int c);
    logic eq;
    if (c % 2 == 0) eq = (w[0] == w[1]);
    else            eq = (w[2] == w[3]);
    return eq ? 4'hF : 4'h0;
  endfunction

  task automatic open_row(input logic [9:0] row);
    addr = row; ras_n = 1'b0;
    tick(1);
    check("R2 evt_valid", 32'(evt_valid), 32'd1);
    check("R2 evt_kind", 32'(evt_kind), 32'd0);
    check("R2 evt_row", 32'(evt_row), 32'(row));
  endtask

  task automatic close_row();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(2);
  endtask

  task automatic col_write(input logic [9:0] col, input logic [3:0] data);
    addr = col; din = data; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0;
    tick(1);
    check("R7 early write quiet", 32'(dq_oe), 32'd0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(1);
  endtask

  task automatic col_read(input logic [9:0] col, input logic [3:0] exp, input string tag);
    addr = col; oe_n = 1'b0; cas_n = 1'b0;
    tick(1);
    check({tag, " dq_oe"}, 32'(dq_oe), 32'd1);
    check({tag, " dout"}, 32'(dout), 32'(exp));
    cas_n = 1'b1;
    #1;
    check("R6 release on column strobe rise", 32'(dq_oe), 32'd0);
    oe_n = 1'b1;
    tick(1);
  endtask

  task automatic ctr_refresh(input logic we_lvl, input logic [1:0] kind, input string tag);
    cas_n = 1'b0; we_n = we_lvl;
    tick(1);
    ras_n = 1'b0;
    tick(1);
    check({tag, " evt_kind"}, 32'(evt_kind), 32'(kind));
    check({tag, " evt_row"}, 32'(evt_row), 32'(exp_ctr));
    check({tag, " test_mode"}, 32'(test_mode), 32'(kind == 2'd2));
    exp_ctr = exp_ctr + 10'd1;
    ras_n = 1'b1;
    tick(1);
    cas_n = 1'b1; we_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0;
    tick(3);
    check("R1 dq_oe", 32'(dq_oe), 32'd0);
    check("R1 dout", 32'(dout), 32'd0);
    check("R1 test_mode", 32'(test_mode), 32'd0);
    check("R1 evt_valid", 32'(evt_valid), 32'd0);
    rst_n = 1'b1;
    tick(2);

    // R1/R3: first counter refresh uses row 0
    ctr_refresh(1'b1, 2'd1, "R1 R3 first refresh");

    // R7/R9: fill the array, one page per row, high address bits varied
    for (int r = 0; r < 8; r++) begin
      open_row(10'(r * 9));
      for (int c = 0; c < 8; c++) begin
        col_write(10'(c | (c << 5)), pat(r, c));
        model[r * 8 + c] = pat(r, c);
      end
      close_row();
    end

    // R6/R9: read back through aliased rows in page mode
    for (int r = 0; r < 8; r++) begin
      open_row(10'(r + 512));
      for (int c = 0; c < 8; c++)
        col_read(10'(c + 8 * (7 - c)), model[r * 8 + c], "R6 R9 page read");
      close_row();
    end

    // R6: output enable high keeps the pins released
    open_row(10'd4);
    addr = 10'd1; oe_n = 1'b1; cas_n = 1'b0;
    tick(1);
    check("R6 oe high released", 32'(dq_oe), 32'd0);
    oe_n = 1'b0;
    #1;
    check("R6 oe low drives", 32'(dq_oe), 32'd1);
    check("R6 oe low data", 32'(dout), 32'(model[4 * 8 + 1]));
    close_row();

    // R8: read-modify-write
    open_row(10'd2);
    addr = 10'd5; oe_n = 1'b0; cas_n = 1'b0;
    tick(1);
    check("R8 read before write", 32'(dout), 32'(model[2 * 8 + 5]));
    din = ~model[2 * 8 + 5]; we_n = 1'b0;
    tick(1);
    check("R8 output held dq_oe", 32'(dq_oe), 32'd1);
    check("R8 output held dout", 32'(dout), 32'(model[2 * 8 + 5]));
    model[2 * 8 + 5] = ~model[2 * 8 + 5];
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(1);
    col_read(10'd5, model[2 * 8 + 5], "R8 readback");
    close_row();

    // R4: enter test mode
    ctr_refresh(1'b0, 2'd2, "R4 test entry");

    // R10: compare read sweep over every location
    for (int r = 0; r < 8; r++) begin
      open_row(10'(r));
      for (int c = 0; c < 8; c++)
        col_read(10'(c), cmp_exp(model[r * 8 + c], c), "R10 compare read");
      close_row();
    end
    check("R5 access keeps test mode", 32'(test_mode), 32'd1);
    ctr_refresh(1'b0, 2'd2, "R4 repeated entry");

    // R5: row cycle with no column access leaves test mode
    addr = 10'd77; ras_n = 1'b0;
    tick(1);
    check("R5 row-only evt_kind", 32'(evt_kind), 32'd0);
    ras_n = 1'b1;
    tick(1);
    check("R5 row-only exit", 32'(test_mode), 32'd0);
    tick(1);

    // R3: plain counter refresh leaves test mode
    ctr_refresh(1'b0, 2'd2, "R4 entry again");
    ctr_refresh(1'b1, 2'd1, "R3 exit");

    // R11: refresh hidden behind a held read
    open_row(10'(3 * 9));
    addr = 10'd4; oe_n = 1'b0; cas_n = 1'b0;
    tick(1);
    check("R11 read data", 32'(dout), 32'(model[3 * 8 + 4]));
    ras_n = 1'b1;
    tick(1);
    ras_n = 1'b0;
    tick(1);
    check("R11 hidden evt_kind", 32'(evt_kind), 32'd1);
    check("R11 hidden evt_row", 32'(evt_row), 32'(exp_ctr));
    check("R11 still driven", 32'(dq_oe), 32'd1);
    check("R11 data unchanged", 32'(dout), 32'(model[3 * 8 + 4]));
    exp_ctr = exp_ctr + 10'd1;
    ras_n = 1'b1;
    tick(1);
    close_row();

    // R12: counter wrap
    while (exp_ctr != 10'd1023) ctr_refresh(1'b1, 2'd1, "R12 sweep");
    ctr_refresh(1'b1, 2'd1, "R12 last row");
    check("R12 model wrapped", 32'(exp_ctr), 32'd0);
    ctr_refresh(1'b1, 2'd1, "R12 wrapped to zero");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule